// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This unit resolves the control-flow outcome of two families of operations: conditional relative branches, and skip-next-instruction operations. For a branch, it picks one bit of the 8-bit status register by a 3-bit index and compares it against a requested polarity. On a match, the counter jumps by a signed relative offset. For a skip, an externally computed condition decides whether the following instruction is stepped over. The size of the step depends on whether that instruction occupies one word or two.

One operation is presented per cycle with `op_valid`. One cycle later the unit registers its result on `out_valid`. The result is the next program counter, a taken indication and the number of cycles the operation costs. Named branch forms are all expressed through the single index-and-polarity test. Examples are equal/not-equal, same-or-higher/lower and signed greater-or-equal/less-than. The signed forms use the sign bit S, which holds N xor V.

Top module: `brsk_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `taken`, `next_pc` and `cycles` are all zero.
- R2: A result appears on the outputs exactly one cycle after `op_valid` is high, with `out_valid` high. In a cycle following `op_valid` low, `out_valid` is low and `next_pc`, `taken` and `cycles` hold their previous values.
- R3: A branch (`is_skip`=0) is taken exactly when `sreg[flag_sel]` equals `want_set`. The status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Signed greater-or-equal is index 4 with `want_set`=0, and signed less-than is index 4 with `want_set`=1. Same-or-higher is index 0 with `want_set`=0, and lower is index 0 with `want_set`=1.
- R4: A taken branch gives `next_pc` = `cur_pc` + sign-extended `rel_off` + 1, wrapping modulo 2^PC_W.
- R5: A branch that is not taken gives `next_pc` = `cur_pc` + 1, `taken`=0 and `cycles`=1.
- R6: A taken branch reports `cycles`=2 and `taken`=1.
- R7: A skip (`is_skip`=1) with `skip_cond`=1 and `next_two_word`=0 gives `next_pc` = `cur_pc` + 2, `taken`=1 and `cycles`=2.
- R8: A skip with `skip_cond`=1 and `next_two_word`=1 gives `next_pc` = `cur_pc` + 3 (wrapping), `taken`=1 and `cycles`=3.
- R9: A skip with `skip_cond`=0 gives `next_pc` = `cur_pc` + 1, `taken`=0 and `cycles`=1, whatever the value of `next_two_word`.
- R10: A branch ignores `skip_cond` and `next_two_word`. A skip ignores `sreg`, `flag_sel`, `want_set` and `rel_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| is_skip | input | 1 | 1 = skip operation, 0 = conditional branch |
| cur_pc | input | PC_W | Program counter of the operation |
| sreg | input | 8 | Status register |
| rel_off | input | OFF_W | Signed relative branch offset |
| flag_sel | input | 3 | Status bit index tested by a branch |
| want_set | input | 1 | Branch if the selected bit is 1 (else if 0) |
| skip_cond | input | 1 | Skip condition from the comparison datapath |
| next_two_word | input | 1 | The following instruction is two words long |
| out_valid | output | 1 | Result registered this cycle |
| next_pc | output | PC_W | Next program counter |
| taken | output | 1 | Branch or skip was taken |
| cycles | output | 2 | Cycle cost of the operation (1, 2 or 3) |

## Verification
The branch test is tried with a one-hot status register for every index, under both polarities. An exchanged or misnumbered bit therefore shows as a wrong decision on exactly one index. Offsets are driven positive, negative and at both extremes, and current PCs are driven near zero and near the top. These cases separate correct sign extension and wrapping from zero extension or a missing +1. Skips are driven in all four combinations of condition and next-instruction length, with branch-only inputs set to values that would change a branch result. This shows that the length bit alone selects +2 or +3, and that unrelated inputs are ignored.

// File: rtl/brsk_pkg.sv
package brsk_pkg;

    localparam int SR_W  = 8;
    localparam int SEL_W = 3;
    localparam int CYC_W = 2;

    // status bit positions; the flag-select index decodes these
    localparam int unsigned FLG_C = 0;
    localparam int unsigned FLG_Z = 1;
    localparam int unsigned FLG_N = 2;
    localparam int unsigned FLG_V = 3;
    localparam int unsigned FLG_S = 4;
    localparam int unsigned FLG_H = 5;
    localparam int unsigned FLG_T = 6;
    localparam int unsigned FLG_I = 7;

    typedef enum logic [CYC_W-1:0] {
        CYC_NONE = 2'd0,
        CYC_ONE  = 2'd1,
        CYC_TWO  = 2'd2,
        CYC_THREE = 2'd3
    } cyc_e;

    // how far the counter moves
    typedef enum logic [1:0] {
        STEP_SEQ   = 2'd0,  // +1
        STEP_REL   = 2'd1,  // +k+1
        STEP_SKIP1 = 2'd2,  // +2
        STEP_SKIP2 = 2'd3   // +3
    } step_e;

    typedef struct packed {
        logic  take;
        step_e step;
        cyc_e  cyc;
    } decision_t;

    function automatic logic pick_flag(input logic [SR_W-1:0] sr,
                                       input logic [SEL_W-1:0] sel,
                                       input logic pol);
        return sr[sel] == pol;
    endfunction

endpackage

// File: rtl/brsk_decide.sv
module brsk_decide
    import brsk_pkg::*;
(
    input  logic              is_skip,
    input  logic [SR_W-1:0]   sreg,
    input  logic [SEL_W-1:0]  flag_sel,
    input  logic              want_set,
    input  logic              skip_cond,
    input  logic              next_two_word,
    output decision_t         dec
);

    logic br_hit;

    always_comb begin
        br_hit = pick_flag(sreg, flag_sel, want_set);
        dec    = '{take: 1'b0, step: STEP_SEQ, cyc: CYC_ONE};
        if (is_skip) begin
            if (skip_cond) begin
                dec.take = 1'b1;
                dec.step = next_two_word ? STEP_SKIP2 : STEP_SKIP1;
                dec.cyc  = next_two_word ? CYC_THREE : CYC_TWO;
            end
        end else if (br_hit) begin
            dec.take = 1'b1;
            dec.step = STEP_REL;
            dec.cyc  = CYC_TWO;
        end
    end

endmodule

// File: rtl/brsk_target.sv
module brsk_target
    import brsk_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 7
) (
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [OFF_W-1:0] rel_off,
    input  step_e            step,
    output logic [PC_W-1:0]  tgt
);

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] incr;

    generate
        if (OFF_W >= PC_W) begin : g_trunc
            assign off_ext = rel_off[PC_W-1:0];
        end else begin : g_sext
            assign off_ext = {{(PC_W-OFF_W){rel_off[OFF_W-1]}}, rel_off};
        end
    endgenerate

    always_comb begin
        unique case (step)
            STEP_REL:   incr = off_ext + PC_W'(1);
            STEP_SKIP1: incr = PC_W'(2);
            STEP_SKIP2: incr = PC_W'(3);
            default:    incr = PC_W'(1);
        endcase
        tgt = cur_pc + incr;
    end

endmodule

// File: rtl/brsk_unit.sv
module brsk_unit
    import brsk_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              is_skip,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [7:0]        sreg,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [2:0]        flag_sel,
    input  logic              want_set,
    input  logic              skip_cond,
    input  logic              next_two_word,
    output logic              out_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken,
    output logic [1:0]        cycles
);

    decision_t       dec;
    logic [PC_W-1:0] tgt;

    brsk_decide u_decide (
        .is_skip       (is_skip),
        .sreg          (sreg),
        .flag_sel      (flag_sel),
        .want_set      (want_set),
        .skip_cond     (skip_cond),
        .next_two_word (next_two_word),
        .dec           (dec)
    );

    brsk_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
        .cur_pc  (cur_pc),
        .rel_off (rel_off),
        .step    (dec.step),
        .tgt     (tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            next_pc   <= '0;
            taken     <= 1'b0;
            cycles    <= CYC_NONE;
        end else begin
            out_valid <= op_valid;
            if (op_valid) begin
                next_pc <= tgt;
                taken   <= dec.take;
                cycles  <= dec.cyc;
            end
        end
    end

endmodule

// File: rtl/brsk_unit_chk.sv
module brsk_unit_chk #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic              is_skip,
    input logic [PC_W-1:0]   cur_pc,
    input logic              skip_cond,
    input logic              next_two_word,
    input logic              out_valid,
    input logic [PC_W-1:0]   next_pc,
    input logic              taken,
    input logic [1:0]        cycles
);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!out_valid && $stable(next_pc) && $stable(cycles)));

    p_untaken_one_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !taken) |-> cycles == 2'd1);

    p_branch_cost_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !is_skip) |=> (taken ? cycles == 2'd2 : cycles == 2'd1));

    p_skip_one_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_skip && skip_cond && !next_two_word) |=>
            (cycles == 2'd2 && next_pc == $past(cur_pc) + PC_W'(2)));

    p_skip_two_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_skip && skip_cond && next_two_word) |=>
            (cycles == 2'd3 && next_pc == $past(cur_pc) + PC_W'(3)));

    p_no_skip_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_skip && !skip_cond) |=>
            (!taken && next_pc == $past(cur_pc) + PC_W'(1)));

endmodule

bind brsk_unit brsk_unit_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .op_valid      (op_valid),
    .is_skip       (is_skip),
    .cur_pc        (cur_pc),
    .skip_cond     (skip_cond),
    .next_two_word (next_two_word),
    .out_valid     (out_valid),
    .next_pc       (next_pc),
    .taken         (taken),
    .cycles        (cycles)
);

// File: tb/brsk_unit_tb_top.sv
module brsk_unit_tb_top;

    localparam int PC_W  = 16;
    localparam int OFF_W = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              op_valid = 1'b0;
    logic              is_skip = 1'b0;
    logic [PC_W-1:0]   cur_pc = '0;
    logic [7:0]        sreg = '0;
    logic [OFF_W-1:0]  rel_off = '0;
    logic [2:0]        flag_sel = '0;
    logic              want_set = 1'b0;
    logic              skip_cond = 1'b0;
    logic              next_two_word = 1'b0;
    logic              out_valid;
    logic [PC_W-1:0]   next_pc;
    logic              taken;
    logic [1:0]        cycles;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    brsk_unit #(.PC_W(PC_W), .OFF_W(OFF_W)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .is_skip(is_skip),
        .cur_pc(cur_pc), .sreg(sreg), .rel_off(rel_off), .flag_sel(flag_sel),
        .want_set(want_set), .skip_cond(skip_cond), .next_two_word(next_two_word),
        .out_valid(out_valid), .next_pc(next_pc), .taken(taken), .cycles(cycles)
    );

    typedef struct packed {
        logic             sk;
        logic [15:0]      pc;
        logic [7:0]       sr;
        logic [6:0]       off;
        logic [2:0]       sel;
        logic             pol;
        logic             sc;
        logic             tw;
        logic [15:0]      e_pc;
        logic             e_tk;
        logic [1:0]       e_cy;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 16'h0100, 8'h02, 7'h05, 3'd1, 1'b1, 1'b0, 1'b0, 16'h0106, 1'b1, 2'd2}, // R4 R6 Z set
        '{1'b0, 16'h0100, 8'h02, 7'h05, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0101, 1'b0, 2'd1}, // R5
        '{1'b0, 16'h0200, 8'h10, 7'h05, 3'd4, 1'b0, 1'b0, 1'b0, 16'h0201, 1'b0, 2'd1}, // R3 signed ge fails
        '{1'b0, 16'h0200, 8'h10, 7'h7E, 3'd4, 1'b1, 1'b0, 1'b0, 16'h01FF, 1'b1, 2'd2}, // R3 signed lt, R4 negative
        '{1'b0, 16'h0000, 8'h01, 7'h40, 3'd0, 1'b1, 1'b0, 1'b0, 16'hFFC1, 1'b1, 2'd2}, // R4 most negative, wrap
        '{1'b0, 16'hFFFF, 8'h00, 7'h3F, 3'd0, 1'b0, 1'b0, 1'b0, 16'h003F, 1'b1, 2'd2}, // R4 most positive, wrap
        '{1'b0, 16'h0300, 8'h80, 7'h01, 3'd7, 1'b1, 1'b1, 1'b1, 16'h0302, 1'b1, 2'd2}, // R10 skip inputs ignored
        '{1'b1, 16'h0400, 8'hFF, 7'h3F, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0402, 1'b1, 2'd2}, // R7 R10
        '{1'b1, 16'h0400, 8'h00, 7'h3F, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0403, 1'b1, 2'd3}, // R8
        '{1'b1, 16'hFFFE, 8'h00, 7'h00, 3'd0, 1'b0, 1'b1, 1'b1, 16'h0001, 1'b1, 2'd3}, // R8 wrap
        '{1'b1, 16'h0500, 8'h01, 7'h20, 3'd0, 1'b1, 1'b0, 1'b1, 16'h0501, 1'b0, 2'd1}, // R9 R10
        '{1'b0, 16'h0010, 8'h40, 7'h02, 3'd6, 1'b0, 1'b1, 1'b0, 16'h0011, 1'b0, 2'd1}  // R5 T set, want clear
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic sk, input logic [15:0] pc, input logic [7:0] sr,
                         input logic [6:0] off, input logic [2:0] sel, input logic pol,
                         input logic sc, input logic tw);
        @(negedge clk);
        op_valid = 1'b1; is_skip = sk; cur_pc = pc; sreg = sr; rel_off = off;
        flag_sel = sel; want_set = pol; skip_cond = sc; next_two_word = tw;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        #400000;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 next_pc",   32'(next_pc),   0);
        check("R1 taken",     32'(taken),     0);
        check("R1 cycles",    32'(cycles),    0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after release", 32'(out_valid), 0);
        check("R1 next_pc after release", 32'(next_pc), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].sk, TBL[i].pc, TBL[i].sr, TBL[i].off, TBL[i].sel,
                  TBL[i].pol, TBL[i].sc, TBL[i].tw);
            check("R2 out_valid", 32'(out_valid), 1);
            check("R4/R5/R7/R8/R9 next_pc R10", 32'(next_pc), 32'(TBL[i].e_pc));
            check("R3 taken", 32'(taken), 32'(TBL[i].e_tk));
            check("R6 cycles", 32'(cycles), 32'(TBL[i].e_cy));
        end

        // R3: every index, both polarities, one-hot and inverted-one-hot status
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 2; p++) begin
                issue(1'b0, 16'h1000, 8'(1 << b), 7'h04, 3'(b), 1'(p), 1'b0, 1'b0);
                check("R3 onehot taken", 32'(taken), 32'(p == 1));
                check("R3 onehot pc", 32'(next_pc), (p == 1) ? 32'h1005 : 32'h1001);
                issue(1'b0, 16'h1000, ~8'(1 << b), 7'h04, 3'(b), 1'(p), 1'b0, 1'b0);
                check("R3 inverted taken", 32'(taken), 32'(p == 0));
            end
        end

        // R2: idle cycles keep outputs and drop out_valid
        issue(1'b1, 16'h2000, 8'h00, 7'h00, 3'd0, 1'b0, 1'b1, 1'b1);
        cur_pc = 16'h7777; skip_cond = 1'b0;
        @(negedge clk);
        check("R2 idle out_valid", 32'(out_valid), 0);
        check("R2 idle next_pc hold", 32'(next_pc), 32'h2003);
        check("R2 idle cycles hold", 32'(cycles), 3);
        check("R2 idle taken hold", 32'(taken), 1);

        // R9: skip not taken with one-word follower
        issue(1'b1, 16'hFFFF, 8'hFF, 7'h3F, 3'd2, 1'b1, 1'b0, 1'b0);
        check("R9 pc wrap", 32'(next_pc), 0);
        check("R9 cycles", 32'(cycles), 1);

        // R1: reset in mid-stream clears the outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 re-reset pc", 32'(next_pc), 0);
        check("R1 re-reset cycles", 32'(cycles), 0);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule